// File: doc/BRIEF.md
# Tag-Renaming Instruction Window

This block merges a register rename map with a circular window of instruction slots. It follows the dataflow style. Each cycle the decode side may offer one instruction. The instruction has an opcode, two architectural source registers and one architectural destination register. Each source is looked up in the rename map. The lookup gives one of two things:

- the operand value itself, marked present;
- the index of the window slot that will produce the value.

The destination register is then mapped to the slot index of the new instruction. That index is the only rename tag the block uses.

A slot becomes a candidate for issue when both operands are present and it has not yet been issued. Each cycle the block sends the oldest candidate to the functional units, counting age from the retire pointer. A single result bus returns a slot tag and a value. Every waiting operand and every rename map entry that still names that tag captures the value. Completion frees a slot. Capacity is returned strictly in ring order, by a retire pointer that only moves past slots that have completed.

The functional units are outside the block and are driven by their user. The user may return the result of an issued slot on any later cycle. The user must never return a tag that is not both occupied and issued.

Top module: `tag_window`

## Requirements
- R1: After reset the window is empty, `iss_valid` is 0 and `ins_ready` is 1. Architectural register r holds the value r and is marked present.
- R2: A source whose map entry is present is copied into the slot as a ready operand. An instruction with both sources ready can issue in the cycle after it is accepted, carrying those operand values.
- R3: Accepting an instruction maps its destination register to the accepted slot tag (`ins_tag`). A later reader of that register waits for that tag. A source that names the instruction's own destination still reads the mapping that existed before the instruction.
- R4: A result bus cycle with tag t fills every waiting slot operand that names t. Those slots may issue in the next cycle with the bus value.
- R5: A map entry takes a broadcast value only while it still names the broadcast tag. After a newer rename of the same register, an older result leaves the register pending on the newer slot.
- R6: A source whose producer is on the result bus in the same cycle the reader is accepted takes the bus value directly and is ready at once.
- R7: When several slots are ready, the issued slot is the first ready one found walking forward from the retire pointer, with wrap-around.
- R8: `iss_valid` is 1 exactly when some occupied slot is ready. A slot is issued only once.
- R9: While all NSLOT slots are occupied, `ins_ready` is 0 and an offered instruction is ignored: no tag is consumed and no mapping changes.
- R10: A completed slot returns capacity only when every older slot has completed. The retire pointer moves at most one slot per cycle, on the edge after the slot at the pointer is seen completed.
- R11: Accepted instructions receive tags 0, 1, … NSLOT-1, 0, … in order. `ins_tag` shows the tag the next accepted instruction will get.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_valid | input | 1 | Decode offers an instruction |
| ins_op | input | OPW | Opcode of the offered instruction |
| ins_src_a | input | log2(NREG) | First source register |
| ins_src_b | input | log2(NREG) | Second source register |
| ins_dst | input | log2(NREG) | Destination register |
| ins_ready | output | 1 | A free slot exists; the offer is taken this cycle |
| ins_tag | output | log2(NSLOT) | Tag the next accepted instruction receives |
| iss_valid | output | 1 | An instruction is being issued |
| iss_tag | output | log2(NSLOT) | Slot tag of the issued instruction |
| iss_op | output | OPW | Opcode of the issued instruction |
| iss_opnd_a | output | DW | First operand value |
| iss_opnd_b | output | DW | Second operand value |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | log2(NSLOT) | Slot that produced the result |
| res_data | input | DW | Result value |

## Verification
Offers are registered on the rising edge. Acceptance shows in `ins_tag` and `ins_ready` in the following cycle. An instruction with ready operands appears on the issue port in that same following cycle. A result driven before an edge wakes its dependants, which can issue in the cycle after that edge. A completion at the retire pointer frees capacity one edge later still, so `ins_ready` rises two cycles after the result. The bench keeps an in-order program model. Every edge it advances that model by the same rules, then compares the outputs against it at the falling edge that follows. Every expectation therefore lands in the cycle the register chain dictates. Random traffic with deep dependency chains is mixed with directed runs for stale results, same-cycle bypass, wrap-around age order and a full window.

// File: rtl/ttw_pkg.sv
// Package: shared defaults for the tag-renaming instruction window.
// Assumes: slot and register counts are powers of two.
package ttw_pkg;
    localparam int DEF_NSLOT = 8;
    localparam int DEF_NREG  = 16;
    localparam int DEF_DW    = 16;
    localparam int DEF_OPW   = 4;
endpackage

// File: rtl/ttw_rename.sv
// Module: rename map. One entry per architectural register holds a presence
// bit and either a value or the tag of the slot that will produce it.
// Two read ports see a same-cycle broadcast (bypass). One write port renames
// a destination, and the write overrides a capture in the same cycle.
// Assumes: NREG is a power of two and DW >= log2(NSLOT).
module ttw_rename #(
    parameter  int NREG  = ttw_pkg::DEF_NREG,
    parameter  int NSLOT = ttw_pkg::DEF_NSLOT,
    parameter  int DW    = ttw_pkg::DEF_DW,
    localparam int RW    = $clog2(NREG),
    localparam int TW    = $clog2(NSLOT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] qa_idx,
    output logic          qa_pres,
    output logic [DW-1:0] qa_fld,
    input  logic [RW-1:0] qb_idx,
    output logic          qb_pres,
    output logic [DW-1:0] qb_fld,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_idx,
    input  logic [TW-1:0] wr_tag,
    input  logic          bc_valid,
    input  logic [TW-1:0] bc_tag,
    input  logic [DW-1:0] bc_data
);
    logic [NREG-1:0] pres_q;
    logic [DW-1:0]   fld_q [NREG];

    // Lookup with bypass of the broadcast on the bus this cycle.
    function automatic logic [DW:0] look(input logic [RW-1:0] idx);
        logic          p;
        logic [DW-1:0] f;
        p = pres_q[idx];
        f = fld_q[idx];
        if (!p && bc_valid && f[TW-1:0] == bc_tag) begin
            p = 1'b1;
            f = bc_data;
        end
        return {p, f};
    endfunction

    assign {qa_pres, qa_fld} = look(qa_idx);
    assign {qb_pres, qb_fld} = look(qb_idx);

    // Map update: rename has priority, otherwise capture a matching tag.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) begin
                pres_q[r] <= 1'b1;
                fld_q[r]  <= DW'(r);
            end else if (wr_en && wr_idx == RW'(r)) begin
                pres_q[r] <= 1'b0;
                fld_q[r]  <= {{(DW-TW){1'b0}}, wr_tag};
            end else if (bc_valid && !pres_q[r] && fld_q[r][TW-1:0] == bc_tag) begin
                pres_q[r] <= 1'b1;
                fld_q[r]  <= bc_data;
            end
        end
    end

    // R3: a renamed register is pending right after the rename.
    p_rename_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !pres_q[$past(wr_idx)]);

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R5: a pending entry ignores results for other tags.
        p_stale_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!pres_q[g] && !(bc_valid && fld_q[g][TW-1:0] == bc_tag)) |=> !pres_q[g]);
    end
endmodule

// File: rtl/ttw_slots.sv
// Module: window slot storage. Each slot keeps use and exec flags, an opcode
// and two operands (presence bit plus tag-or-value). It wakes operands on a
// tag match and clears use when its own result is broadcast.
// Assumes: the inserted slot is free, results only name issued slots.
module ttw_slots #(
    parameter  int NSLOT = ttw_pkg::DEF_NSLOT,
    parameter  int DW    = ttw_pkg::DEF_DW,
    parameter  int OPW   = ttw_pkg::DEF_OPW,
    localparam int TW    = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [TW-1:0]    ins_slot,
    input  logic [OPW-1:0]   ins_op,
    input  logic             ins_ap,
    input  logic [DW-1:0]    ins_af,
    input  logic             ins_bp,
    input  logic [DW-1:0]    ins_bf,
    input  logic             iss_en,
    input  logic [TW-1:0]    iss_slot,
    input  logic             bc_valid,
    input  logic [TW-1:0]    bc_tag,
    input  logic [DW-1:0]    bc_data,
    output logic [NSLOT-1:0] use_vec,
    output logic [NSLOT-1:0] rdy_vec,
    output logic [OPW-1:0]   rd_op,
    output logic [DW-1:0]    rd_a,
    output logic [DW-1:0]    rd_b
);
    logic [NSLOT-1:0] use_q, exec_q, ap_q, bp_q;
    logic [OPW-1:0]   op_q [NSLOT];
    logic [DW-1:0]    af_q [NSLOT];
    logic [DW-1:0]    bf_q [NSLOT];

    // Slot state: fill on insert, mark on issue, wake and free on broadcast.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (!rst_n) begin
                use_q[i]  <= 1'b0;
                exec_q[i] <= 1'b0;
                ap_q[i]   <= 1'b0;
                bp_q[i]   <= 1'b0;
                op_q[i]   <= '0;
                af_q[i]   <= '0;
                bf_q[i]   <= '0;
            end else if (ins_en && ins_slot == TW'(i)) begin
                use_q[i]  <= 1'b1;
                exec_q[i] <= 1'b0;
                op_q[i]   <= ins_op;
                ap_q[i]   <= ins_ap;
                af_q[i]   <= ins_af;
                bp_q[i]   <= ins_bp;
                bf_q[i]   <= ins_bf;
            end else begin
                if (iss_en && iss_slot == TW'(i))
                    exec_q[i] <= 1'b1;
                if (bc_valid && bc_tag == TW'(i))
                    use_q[i] <= 1'b0;
                if (bc_valid && use_q[i] && !ap_q[i] && af_q[i][TW-1:0] == bc_tag) begin
                    ap_q[i] <= 1'b1;
                    af_q[i] <= bc_data;
                end
                if (bc_valid && use_q[i] && !bp_q[i] && bf_q[i][TW-1:0] == bc_tag) begin
                    bp_q[i] <= 1'b1;
                    bf_q[i] <= bc_data;
                end
            end
        end
    end

    // Candidate vector and read port for the selected slot.
    always_comb begin
        use_vec = use_q;
        rdy_vec = use_q & ~exec_q & ap_q & bp_q;
        rd_op   = op_q[iss_slot];
        rd_a    = af_q[iss_slot];
        rd_b    = bf_q[iss_slot];
    end

    // R8: an issued slot has not been issued before.
    p_single_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_en |-> (use_q[iss_slot] && !exec_q[iss_slot]));
    // R4: a broadcast names an occupied, issued slot.
    p_result_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |-> (use_q[bc_tag] && exec_q[bc_tag]));
    // R9: insertion never lands on a slot still in use.
    p_insert_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> !use_q[ins_slot]);
endmodule

// File: rtl/ttw_pick.sv
// Module: oldest-first select. Walks the ready vector from the retire pointer
// and returns the first ready slot.
// Assumes: NSLOT is a power of two so the tag addition wraps naturally.
module ttw_pick #(
    parameter  int NSLOT = ttw_pkg::DEF_NSLOT,
    localparam int TW    = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] rdy,
    input  logic [TW-1:0]    head,
    output logic             found,
    output logic [TW-1:0]    idx
);
    // Scan from youngest to oldest so the oldest hit is the last assignment.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = NSLOT - 1; k >= 0; k--) begin
            if (rdy[head + TW'(k)]) begin
                found = 1'b1;
                idx   = head + TW'(k);
            end
        end
    end

    // R7: the chosen slot is ready, and any ready slot produces a choice.
    p_pick_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> rdy[idx]);
    p_pick_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|rdy) |-> found);
endmodule

// File: rtl/tag_window.sv
// Module: top of the tag-renaming instruction window. Owns the allocate and
// retire pointers and the occupancy count, and wires rename map, slots and
// oldest-first select together. Issue is combinational from slot state.
// Assumes: functional units accept every issue and return each tag once.
module tag_window #(
    parameter  int NSLOT = ttw_pkg::DEF_NSLOT,
    parameter  int NREG  = ttw_pkg::DEF_NREG,
    parameter  int DW    = ttw_pkg::DEF_DW,
    parameter  int OPW   = ttw_pkg::DEF_OPW,
    localparam int TW    = $clog2(NSLOT),
    localparam int RW    = $clog2(NREG),
    localparam int CW    = $clog2(NSLOT + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ins_valid,
    input  logic [OPW-1:0] ins_op,
    input  logic [RW-1:0]  ins_src_a,
    input  logic [RW-1:0]  ins_src_b,
    input  logic [RW-1:0]  ins_dst,
    output logic           ins_ready,
    output logic [TW-1:0]  ins_tag,
    output logic           iss_valid,
    output logic [TW-1:0]  iss_tag,
    output logic [OPW-1:0] iss_op,
    output logic [DW-1:0]  iss_opnd_a,
    output logic [DW-1:0]  iss_opnd_b,
    input  logic           res_valid,
    input  logic [TW-1:0]  res_tag,
    input  logic [DW-1:0]  res_data
);
    logic [TW-1:0]    head_q, tail_q;
    logic [CW-1:0]    cnt_q;
    logic             fire, retire;
    logic             a_pres, b_pres;
    logic [DW-1:0]    a_fld, b_fld;
    logic [NSLOT-1:0] use_vec, rdy_vec;

    // Ring increment for slot pointers.
    function automatic logic [TW-1:0] ring_inc(input logic [TW-1:0] p);
        return (p == TW'(NSLOT - 1)) ? '0 : p + 1'b1;
    endfunction

    // Edge handshake and in-order retire of the oldest completed slot.
    always_comb begin
        ins_ready = (cnt_q != CW'(NSLOT));
        ins_tag   = tail_q;
        fire      = ins_valid && ins_ready;
        retire    = (cnt_q != '0) && !use_vec[head_q];
    end

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (fire)   tail_q <= ring_inc(tail_q);
            if (retire) head_q <= ring_inc(head_q);
            case ({fire, retire})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    ttw_rename #(.NREG(NREG), .NSLOT(NSLOT), .DW(DW)) u_rename (
        .clk      (clk),
        .rst_n    (rst_n),
        .qa_idx   (ins_src_a),
        .qa_pres  (a_pres),
        .qa_fld   (a_fld),
        .qb_idx   (ins_src_b),
        .qb_pres  (b_pres),
        .qb_fld   (b_fld),
        .wr_en    (fire),
        .wr_idx   (ins_dst),
        .wr_tag   (tail_q),
        .bc_valid (res_valid),
        .bc_tag   (res_tag),
        .bc_data  (res_data)
    );

    ttw_slots #(.NSLOT(NSLOT), .DW(DW), .OPW(OPW)) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (fire),
        .ins_slot (tail_q),
        .ins_op   (ins_op),
        .ins_ap   (a_pres),
        .ins_af   (a_fld),
        .ins_bp   (b_pres),
        .ins_bf   (b_fld),
        .iss_en   (iss_valid),
        .iss_slot (iss_tag),
        .bc_valid (res_valid),
        .bc_tag   (res_tag),
        .bc_data  (res_data),
        .use_vec  (use_vec),
        .rdy_vec  (rdy_vec),
        .rd_op    (iss_op),
        .rd_a     (iss_opnd_a),
        .rd_b     (iss_opnd_b)
    );

    ttw_pick #(.NSLOT(NSLOT)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .rdy   (rdy_vec),
        .head  (head_q),
        .found (iss_valid),
        .idx   (iss_tag)
    );

    // R9: occupancy never exceeds the slot count.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(NSLOT));
    // R9: a refused offer consumes no tag.
    p_stall_keeps_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready) |=> ins_tag == $past(ins_tag));
    // R10: the retire pointer waits on an unfinished oldest slot.
    p_head_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && use_vec[head_q]) |=> head_q == $past(head_q));
    // R8: the same slot is never issued in two consecutive cycles.
    p_no_reissue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !(iss_valid && iss_tag == $past(iss_tag)));
endmodule

// File: tb/tag_window_bench.sv
// Bench: in-order program model advanced per edge, outputs compared at the
// following falling edge. Random traffic plus directed corner cases.
module tag_window_bench;
    localparam int NS = 8;
    localparam int NR = 16;
    localparam int DW = 16;
    localparam int OW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ins_valid = 1'b0;
    logic [OW-1:0] ins_op = '0;
    logic [3:0]    ins_src_a = '0, ins_src_b = '0, ins_dst = '0;
    logic          ins_ready;
    logic [2:0]    ins_tag;
    logic          iss_valid;
    logic [2:0]    iss_tag;
    logic [OW-1:0] iss_op;
    logic [DW-1:0] iss_opnd_a, iss_opnd_b;
    logic          res_valid = 1'b0;
    logic [2:0]    res_tag = '0;
    logic [DW-1:0] res_data = '0;

    always #10 clk = ~clk;

    tag_window #(.NSLOT(NS), .NREG(NR), .DW(DW), .OPW(OW)) u_tag_window (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
        .ins_src_a(ins_src_a), .ins_src_b(ins_src_b), .ins_dst(ins_dst),
        .ins_ready(ins_ready), .ins_tag(ins_tag), .iss_valid(iss_valid),
        .iss_tag(iss_tag), .iss_op(iss_op), .iss_opnd_a(iss_opnd_a),
        .iss_opnd_b(iss_opnd_b), .res_valid(res_valid), .res_tag(res_tag),
        .res_data(res_data));

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Program-order model: architectural values, pending producers, slots.
    logic [DW-1:0] a_val [NR];
    int            a_tag [NR];
    bit            m_use [NS], m_exec [NS];
    int            m_pa [NS], m_pb [NS];
    logic [DW-1:0] m_ea [NS], m_eb [NS], m_res [NS];
    logic [OW-1:0] m_op [NS];
    int            m_head = 0, m_tail = 0, m_cnt = 0;

    function automatic logic [DW-1:0] fu_fn(logic [OW-1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
        return a + {b[DW-2:0], 1'b0} + DW'(op);
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int model_pick();
        for (int k = 0; k < m_cnt; k++) begin
            int t;
            t = (m_head + k) % NS;
            if (m_use[t] && !m_exec[t] && m_pa[t] < 0 && m_pb[t] < 0) return t;
        end
        return -1;
    endfunction

    function automatic int pick_flight();
        int c[$];
        for (int t = 0; t < NS; t++) if (m_use[t] && m_exec[t]) c.push_back(t);
        if (c.size() == 0) return -1;
        return c[$urandom_range(0, c.size() - 1)];
    endfunction

    // One cycle: check outputs against the model, then drive and advance it.
    task automatic step(bit di, logic [OW-1:0] op, int sa, int sb, int sd,
                        bit dr, int rt, string req);
        int pk;
        bit ret, fire, rv;
        chk("R9", {"ins_ready ", req}, ins_ready, m_cnt != NS);
        chk("R11", "ins_tag", ins_tag, m_tail);
        pk = model_pick();
        chk("R8", "iss_valid", iss_valid, pk >= 0);
        if (pk >= 0 && iss_valid) begin
            chk("R7", "iss_tag", iss_tag, pk);
            chk(req, "iss_op", iss_op, m_op[pk]);
            chk(req, "opnd_a", iss_opnd_a, m_ea[pk]);
            chk(req, "opnd_b", iss_opnd_b, m_eb[pk]);
        end
        ret  = m_cnt != 0 && !m_use[m_head];
        fire = di && (m_cnt != NS);
        rv   = dr && rt >= 0 && rt < NS && m_use[rt] && m_exec[rt];
        if (pk >= 0) m_exec[pk] = 1;
        res_valid = rv;
        res_tag   = 3'(rv ? rt : 0);
        res_data  = rv ? m_res[rt] : '0;
        if (rv) begin
            m_use[rt] = 0;
            for (int t = 0; t < NS; t++) begin
                if (m_pa[t] == rt) m_pa[t] = -1;
                if (m_pb[t] == rt) m_pb[t] = -1;
            end
            for (int r = 0; r < NR; r++) if (a_tag[r] == rt) a_tag[r] = -1;
        end
        ins_valid = di;
        ins_op    = op;
        ins_src_a = 4'(sa);
        ins_src_b = 4'(sb);
        ins_dst   = 4'(sd);
        if (fire) begin
            int t;
            t = m_tail;
            m_pa[t] = a_tag[sa];
            m_pb[t] = a_tag[sb];
            m_ea[t] = a_val[sa];
            m_eb[t] = a_val[sb];
            m_op[t] = op;
            m_res[t] = fu_fn(op, a_val[sa], a_val[sb]);
            m_use[t] = 1;
            m_exec[t] = 0;
            a_val[sd] = m_res[t];
            a_tag[sd] = t;
            m_tail = (t + 1) % NS;
        end
        if (ret) m_head = (m_head + 1) % NS;
        m_cnt = m_cnt + (fire ? 1 : 0) - (ret ? 1 : 0);
        @(negedge clk);
    endtask

    task automatic idle(int n, string req);
        repeat (n) step(0, '0, 0, 0, 0, 0, -1, req);
    endtask

    task automatic drain(string req);
        for (int g = 0; g < 400 && m_cnt != 0; g++)
            step(0, '0, 0, 0, 0, 1, pick_flight(), req);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int t0, t1;
        void'($urandom(32'd20211));
        for (int r = 0; r < NR; r++) begin a_val[r] = DW'(r); a_tag[r] = -1; end
        for (int t = 0; t < NS; t++) begin m_use[t] = 0; m_exec[t] = 0; m_pa[t] = -1; m_pb[t] = -1; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values read as register index; first checks see empty window.
        step(1, 4'd1, 3, 5, 8, 0, -1, "R1");
        step(0, '0, 0, 0, 0, 0, -1, "R1");
        drain("R2");

        // R3 and R4: reader waits on a held producer, then wakes on broadcast.
        t0 = m_tail;
        step(1, 4'd2, 1, 1, 2, 0, -1, "R3");
        step(1, 4'd3, 2, 4, 9, 0, -1, "R3");
        idle(3, "R3");
        step(0, '0, 0, 0, 0, 1, t0, "R4");
        step(0, '0, 0, 0, 0, 0, -1, "R4");
        drain("R4");

        // R5: newer rename survives an older result arriving last.
        t0 = m_tail;
        step(1, 4'd5, 1, 2, 4, 0, -1, "R5");
        t1 = m_tail;
        step(1, 4'd6, 3, 3, 4, 0, -1, "R5");
        idle(2, "R5");
        step(0, '0, 0, 0, 0, 1, t1, "R5");
        step(1, 4'd7, 4, 0, 10, 1, t0, "R5");
        idle(2, "R5");
        drain("R5");

        // R6: reader accepted in the cycle its producer broadcasts.
        t0 = m_tail;
        step(1, 4'd8, 5, 6, 6, 0, -1, "R6");
        step(0, '0, 0, 0, 0, 0, -1, "R6");
        step(1, 4'd9, 6, 6, 11, 1, t0, "R6");
        step(0, '0, 0, 0, 0, 0, -1, "R6");
        drain("R6");

        // R9 and R10: fill the window, stall, free youngest then oldest.
        t0 = m_tail;
        for (int i = 0; i < NS; i++) step(1, 4'(i), 1, 2, 12, 0, -1, "R11");
        for (int i = 0; i < NS; i++) step(1, 4'd15, 3, 4, 13, 0, -1, "R9");
        step(1, 4'd15, 3, 4, 13, 1, (t0 + NS - 1) % NS, "R10");
        step(1, 4'd15, 3, 4, 13, 0, -1, "R10");
        step(1, 4'd15, 3, 4, 13, 0, -1, "R10");
        step(1, 4'd15, 3, 4, 13, 1, t0, "R10");
        step(1, 4'd14, 12, 13, 12, 0, -1, "R10");
        step(1, 4'd14, 12, 13, 14, 0, -1, "R10");
        drain("R10");

        // Random traffic: dense dependencies over eight registers, wrap-around.
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 99) < 60, 4'($urandom_range(0, 15)),
                 $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                 $urandom_range(0, 1), pick_flight(), "R2");
        end
        drain("R7");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule